// File: doc/BRIEF.md
# One-Wire Bus Master Controller

This block is a bus master for a single-wire, open-drain serial bus. Software reaches it through a small 16-bit register interface. It can start a bus reset with presence detection, a single write-0 slot, or a single write-1 slot that doubles as a read slot. Each start is a control bit that stays set while its operation runs and clears by itself when the operation ends. A programmable divider turns the system clock into a time base of about one microsecond. Every bus duration is counted in ticks of that time base.

A byte path uses the same slot engine. Writing a byte to the data register queues it behind a one-byte transmit buffer. The byte goes out as eight slots, least significant bit first. Each 1 bit is sent as a read slot, so writing 0xFF reads a full byte. The received byte collects in a receive shift register and then moves to a receive buffer. Four status flags report the state of the two buffers and the two shift registers. An enable mask routes any of these flags to one level-sensitive interrupt.

The data line is modelled as an output enable (1 pulls the line low) and a sampled input. The input passes through a two-flop synchroniser.

Top module: `owire_master`

## Requirements
- R1: Writing 1 to control bit 7 (offset 0) starts a reset cycle. The line is pulled low for 480 ticks and then released. The cycle lasts 960 ticks in total. Bit 7 reads 1 for exactly the length of the cycle and 0 afterwards.
- R2: Control bit 6 reads 1 when the line was low at tick 70 after the reset cycle released it, and 0 when the line was high. The bit keeps its value until the next reset cycle.
- R3: Writing 1 to control bit 5 starts a write-0 slot of 70 ticks. The line is low for the first 60 ticks. Bit 5 reads 1 for the length of the slot.
- R4: Writing 1 to control bit 4 starts a write-1/read slot of 70 ticks. The line is low for the first 6 ticks. Control bit 3 takes the line value sampled at tick 15. Bit 4 reads 1 for the length of the slot.
- R5: The divider register (offset 1) holds N-1, and one tick lasts N system clocks. Its value after reset is 0.
- R6: A start request written while a reset cycle or slot is running is ignored. The running operation keeps its length and the requested bit reads 0.
- R7: A byte written to the data register (offset 4) is sent as eight slots, least significant bit first. A 0 bit is sent as a write-0 slot and a 1 bit as a write-1/read slot.
- R8: The eight bits sampled during a byte are assembled least significant bit first. A 0 bit that was sent counts as 0. When the byte is complete it moves to the receive buffer and status bit 4 (receive full) is set. Reading the data register returns the byte in bits 7:0 and clears bit 4.
- R9: Status bit 2 (transmit buffer empty) is 0 while a written byte waits for the shifter. Status bit 3 (shift register empty) is 0 while a byte is being shifted. Both read 1 when the block is idle.
- R10: If a byte completes while the receive buffer is still full, status bit 5 (receive shift full) is set and shifting stalls. A read of the data register then returns the older byte and moves the newer one into the buffer. After that move, bit 5 is 0 and bit 4 stays 1.
- R11: The interrupt output is high exactly when some status bit in 5:2 and the same bit of the enable register (offset 6) are both 1.
- R12: Writing 1 to bit 0 of offset 2 aborts any cycle or byte. The line is released on the next clock. Control bits 7, 5 and 4 read 0, and the status reads 0x000C.
- R13: After reset the line is released, control reads 0, status reads 0x000C and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| dq_oe | output | 1 | 1 pulls the bus line low |
| dq_in | input | 1 | Bus line level |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume three things about the inputs. The divider register is written only while no cycle or slot is running, so the tick spacing stays constant. Shifting stalls whenever the receive shift register is full. The data line settles well away from the sampling ticks. The bench writes the divider only between operations. The device model changes its pull only when a slot begins. Two bytes are queued only when the expected overflow condition is being tested.

// File: rtl/owm_pkg.sv
package owm_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BYTE_W = 8;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_SRST = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DATA = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_IEN  = 3'd6;

  localparam int unsigned CB_RST  = 7;
  localparam int unsigned CB_PRES = 6;
  localparam int unsigned CB_W0   = 5;
  localparam int unsigned CB_W1   = 4;
  localparam int unsigned CB_RBIT = 3;

  localparam int unsigned SB_LO = 2;
  localparam int unsigned SB_HI = 5;

  typedef enum logic [1:0] {ENG_IDLE, ENG_RESET, ENG_SLOT} eng_state_e;
  typedef enum logic [1:0] {SH_IDLE, SH_REQ, SH_WAIT} sh_state_e;
endpackage

// File: rtl/owm_timebase.sv
module owm_timebase #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q >= div_val);

  always_comb begin
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && div_val != '0) |=> !tick);
endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
  import owm_pkg::*;
#(
  parameter int unsigned RST_LOW   = 480,
  parameter int unsigned PRES_AT   = 70,
  parameter int unsigned RST_TAIL  = 410,
  parameter int unsigned W0_LOW    = 60,
  parameter int unsigned W1_LOW    = 6,
  parameter int unsigned SAMPLE_AT = 15,
  parameter int unsigned SLOT_LEN  = 60,
  parameter int unsigned REC       = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic tick,
  input  logic start_rst,
  input  logic start_slot,
  input  logic slot_val,
  input  logic line_in,
  output logic launch,
  output logic slot_done,
  output logic rst_busy,
  output logic w0_busy,
  output logic w1_busy,
  output logic busy,
  output logic line_oe,
  output logic presence,
  output logic rd_bit
);
  localparam int unsigned RST_TOTAL  = RST_LOW + PRES_AT + RST_TAIL;
  localparam int unsigned SLOT_TOTAL = SLOT_LEN + REC;
  localparam int unsigned CNT_W      = $clog2(RST_TOTAL + 1);
  localparam logic [CNT_W-1:0] C_RST_LAST  = CNT_W'(RST_TOTAL - 1);
  localparam logic [CNT_W-1:0] C_PRES      = CNT_W'(RST_LOW + PRES_AT);
  localparam logic [CNT_W-1:0] C_RST_LOW   = CNT_W'(RST_LOW);
  localparam logic [CNT_W-1:0] C_SLOT_LAST = CNT_W'(SLOT_TOTAL - 1);
  localparam logic [CNT_W-1:0] C_SAMPLE    = CNT_W'(SAMPLE_AT);
  localparam logic [CNT_W-1:0] C_W0_LOW    = CNT_W'(W0_LOW);
  localparam logic [CNT_W-1:0] C_W1_LOW    = CNT_W'(W1_LOW);

  eng_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             val_q, val_d, pres_q, pres_d, rdb_q, rdb_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    val_d     = val_q;
    pres_d    = pres_q;
    rdb_d     = rdb_q;
    launch    = 1'b0;
    slot_done = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (start_rst) begin
          state_d = ENG_RESET;
          cnt_d   = '0;
          launch  = 1'b1;
        end else if (start_slot) begin
          state_d = ENG_SLOT;
          cnt_d   = '0;
          val_d   = slot_val;
          launch  = 1'b1;
        end
      end
      ENG_RESET: begin
        if (tick) begin
          if (cnt_q == C_PRES) pres_d = ~line_in;
          if (cnt_q == C_RST_LAST) state_d = ENG_IDLE;
          else                     cnt_d   = cnt_q + 1'b1;
        end
      end
      ENG_SLOT: begin
        if (tick) begin
          if (val_q && cnt_q == C_SAMPLE) rdb_d = line_in;
          if (cnt_q == C_SLOT_LAST) begin
            state_d   = ENG_IDLE;
            slot_done = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
    if (abort) begin
      state_d   = ENG_IDLE;
      cnt_d     = '0;
      launch    = 1'b0;
      slot_done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      val_q   <= 1'b0;
      pres_q  <= 1'b0;
      rdb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      val_q   <= val_d;
      pres_q  <= pres_d;
      rdb_q   <= rdb_d;
    end
  end

  assign rst_busy = (state_q == ENG_RESET);
  assign w0_busy  = (state_q == ENG_SLOT) && !val_q;
  assign w1_busy  = (state_q == ENG_SLOT) && val_q;
  assign busy     = (state_q != ENG_IDLE);
  assign line_oe  = (rst_busy && cnt_q < C_RST_LOW) ||
                    (w0_busy && cnt_q < C_W0_LOW) ||
                    (w1_busy && cnt_q < C_W1_LOW);
  assign presence = pres_q;
  assign rd_bit   = rdb_q;

  // R1
  oe_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> $past(launch));
  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_SLOT && start_rst && !slot_done) |=> (state_q != ENG_RESET));
  // R2
  pres_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ENG_RESET) |=> $stable(pres_q));
endmodule

// File: rtl/owm_byte_shifter.sv
module owm_byte_shifter
  import owm_pkg::*;
#(
  parameter int unsigned BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          wr_byte,
  input  logic [BW-1:0] wr_data,
  input  logic          rd_byte,
  input  logic          slot_grant,
  input  logic          slot_done,
  input  logic          rd_bit,
  output logic          slot_req,
  output logic          slot_bit,
  output logic          tbe,
  output logic          tsre,
  output logic          rbf,
  output logic          rsrf,
  output logic [BW-1:0] rx_byte
);
  localparam int unsigned IDX_W = $clog2(BW);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BW - 1);

  sh_state_e        st_q, st_d;
  logic [BW-1:0]    txbuf_q, txbuf_d, sh_q, sh_d, rxsh_q, rxsh_d, rxbuf_q, rxbuf_d;
  logic [BW-1:0]    rx_next;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             txfull_q, txfull_d, rbf_q, rbf_d, rsrf_q, rsrf_d;

  assign rx_next = {sh_q[0] & rd_bit, rxsh_q[BW-1:1]};

  always_comb begin
    st_d     = st_q;
    txbuf_d  = txbuf_q;
    txfull_d = txfull_q;
    sh_d     = sh_q;
    idx_d    = idx_q;
    rxsh_d   = rxsh_q;
    rxbuf_d  = rxbuf_q;
    rbf_d    = rbf_q;
    rsrf_d   = rsrf_q;
    if (rd_byte) begin
      if (rsrf_q) begin
        rxbuf_d = rxsh_q;
        rsrf_d  = 1'b0;
      end else begin
        rbf_d = 1'b0;
      end
    end
    case (st_q)
      SH_IDLE: begin
        if (txfull_q && !rsrf_q) begin
          sh_d     = txbuf_q;
          txfull_d = 1'b0;
          idx_d    = '0;
          st_d     = SH_REQ;
        end
      end
      SH_REQ: if (slot_grant) st_d = SH_WAIT;
      SH_WAIT: begin
        if (slot_done) begin
          sh_d = sh_q >> 1;
          if (idx_q == IDX_LAST) begin
            st_d = SH_IDLE;
            if (!rbf_d) begin
              rxbuf_d = rx_next;
              rbf_d   = 1'b1;
            end else begin
              rxsh_d = rx_next;
              rsrf_d = 1'b1;
            end
          end else begin
            rxsh_d = rx_next;
            idx_d  = idx_q + 1'b1;
            st_d   = SH_REQ;
          end
        end
      end
      default: st_d = SH_IDLE;
    endcase
    if (wr_byte) begin
      txbuf_d  = wr_data;
      txfull_d = 1'b1;
    end
    if (abort) begin
      st_d     = SH_IDLE;
      txfull_d = 1'b0;
      rbf_d    = 1'b0;
      rsrf_d   = 1'b0;
      idx_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SH_IDLE;
      txbuf_q  <= '0;
      txfull_q <= 1'b0;
      sh_q     <= '0;
      idx_q    <= '0;
      rxsh_q   <= '0;
      rxbuf_q  <= '0;
      rbf_q    <= 1'b0;
      rsrf_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      txbuf_q  <= txbuf_d;
      txfull_q <= txfull_d;
      sh_q     <= sh_d;
      idx_q    <= idx_d;
      rxsh_q   <= rxsh_d;
      rxbuf_q  <= rxbuf_d;
      rbf_q    <= rbf_d;
      rsrf_q   <= rsrf_d;
    end
  end

  assign slot_req = (st_q == SH_REQ);
  assign slot_bit = sh_q[0];
  assign tbe      = !txfull_q;
  assign tsre     = (st_q == SH_IDLE);
  assign rbf      = rbf_q;
  assign rsrf     = rsrf_q;
  assign rx_byte  = rxbuf_q;

  // R10
  rsrf_needs_rbf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsrf_q |-> rbf_q);
  // R10
  stall_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsrf_q && !rd_byte && !abort) |=> (st_q == SH_IDLE));
endmodule

// File: rtl/owire_master.sv
module owire_master
  import owm_pkg::*;
#(
  parameter int unsigned DIV_W     = REG_W,
  parameter int unsigned DIV_RST   = 0,
  parameter int unsigned RST_LOW   = 480,
  parameter int unsigned PRES_AT   = 70,
  parameter int unsigned RST_TAIL  = 410,
  parameter int unsigned W0_LOW    = 60,
  parameter int unsigned W1_LOW    = 6,
  parameter int unsigned SAMPLE_AT = 15,
  parameter int unsigned SLOT_LEN  = 60,
  parameter int unsigned REC       = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        dq_oe,
  input  logic        dq_in,
  output logic        irq
);
  localparam int unsigned SB_N = SB_HI - SB_LO + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [1:0]       dq_sync_q;
  logic [DIV_W-1:0] div_q;
  logic [SB_N-1:0]  ien_q, stat;
  logic             div_we, ien_we, ctrl_we, sreset;
  logic             c_rst, c_w0, c_w1, c_any;
  logic             tick, launch, slot_done, rst_busy, w0_busy, w1_busy, busy;
  logic             presence, rd_bit, line_oe;
  logic             sh_req, sh_bit, grant, tbe, tsre, rbf, rsrf;
  logic [BYTE_W-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) dq_sync_q <= 2'b11;
    else         dq_sync_q <= {dq_sync_q[0], dq_in};
  end

  assign ctrl_we = bus_wr && bus_addr == ADR_CTRL;
  assign div_we  = bus_wr && bus_addr == ADR_DIV;
  assign ien_we  = bus_wr && bus_addr == ADR_IEN;
  assign sreset  = bus_wr && bus_addr == ADR_SRST && bus_wdata[0];
  assign c_rst   = ctrl_we && bus_wdata[CB_RST];
  assign c_w0    = ctrl_we && bus_wdata[CB_W0];
  assign c_w1    = ctrl_we && bus_wdata[CB_W1];
  assign c_any   = c_rst || c_w0 || c_w1;
  assign grant   = sh_req && !c_any && !busy && !sreset;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_W'(DIV_RST);
      ien_q <= '0;
    end else begin
      if (div_we) div_q <= bus_wdata[DIV_W-1:0];
      if (ien_we) ien_q <= bus_wdata[SB_HI:SB_LO];
    end
  end

  owm_timebase #(.DIV_W(DIV_W)) u_tb (
    .clk(clk), .rst_n(rst_ni), .div_val(div_q), .restart(launch), .tick(tick)
  );

  owm_slot_engine #(
    .RST_LOW(RST_LOW), .PRES_AT(PRES_AT), .RST_TAIL(RST_TAIL), .W0_LOW(W0_LOW),
    .W1_LOW(W1_LOW), .SAMPLE_AT(SAMPLE_AT), .SLOT_LEN(SLOT_LEN), .REC(REC)
  ) u_eng (
    .clk(clk), .rst_n(rst_ni), .abort(sreset), .tick(tick),
    .start_rst(c_rst), .start_slot(c_w0 || c_w1 || grant),
    .slot_val((c_w0 || c_w1) ? !c_w0 : sh_bit),
    .line_in(dq_sync_q[1]), .launch(launch), .slot_done(slot_done),
    .rst_busy(rst_busy), .w0_busy(w0_busy), .w1_busy(w1_busy), .busy(busy),
    .line_oe(line_oe), .presence(presence), .rd_bit(rd_bit)
  );

  owm_byte_shifter #(.BW(BYTE_W)) u_sh (
    .clk(clk), .rst_n(rst_ni), .abort(sreset),
    .wr_byte(bus_wr && bus_addr == ADR_DATA && !sreset),
    .wr_data(bus_wdata[BYTE_W-1:0]),
    .rd_byte(bus_rd && bus_addr == ADR_DATA),
    .slot_grant(grant), .slot_done(slot_done), .rd_bit(rd_bit),
    .slot_req(sh_req), .slot_bit(sh_bit),
    .tbe(tbe), .tsre(tsre), .rbf(rbf), .rsrf(rsrf), .rx_byte(rx_byte)
  );

  assign stat  = {rsrf, rbf, tsre, tbe};
  assign irq   = |(stat & ien_q);
  assign dq_oe = line_oe;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTRL: begin
        bus_rdata[CB_RST]  = rst_busy;
        bus_rdata[CB_PRES] = presence;
        bus_rdata[CB_W0]   = w0_busy;
        bus_rdata[CB_W1]   = w1_busy;
        bus_rdata[CB_RBIT] = rd_bit;
      end
      ADR_DIV:  bus_rdata[DIV_W-1:0]   = div_q;
      ADR_DATA: bus_rdata[BYTE_W-1:0]  = rx_byte;
      ADR_STAT: bus_rdata[SB_HI:SB_LO] = stat;
      ADR_IEN:  bus_rdata[SB_HI:SB_LO] = ien_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R12
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sreset |=> (!dq_oe && !busy));
endmodule

// File: tb/owire_master_bench.sv
module owire_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        dq_oe, irq;
  logic        dev_low = 1'b0;
  logic        dev_en = 1'b0;
  logic [15:0] dev_pat = 16'h0;
  int          dev_idx = 0;
  logic [7:0]  cap = 8'h0;
  int          slot_cnt = 0;
  int          ndiv = 1;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;
  logic        prev_oe = 1'b0;
  int          run = 0;

  localparam logic [2:0] A_CTRL = 3'd0, A_DIV = 3'd1, A_SRST = 3'd2,
                         A_DATA = 3'd4, A_STAT = 3'd5, A_IEN = 3'd6;

  always #5 clk = ~clk;

  owire_master u_owire_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .dq_oe(dq_oe),
    .dq_in(~(dq_oe | dev_low)), .irq(irq)
  );

  // device model and slot recorder
  initial forever begin
    @(negedge clk);
    if (dq_oe && !prev_oe) begin
      run = 0;
      if (dev_en) begin
        dev_low = !dev_pat[dev_idx[3:0]];
        dev_idx = dev_idx + 1;
      end
    end
    if (dq_oe) run = run + 1;
    if (!dq_oe && prev_oe) begin
      cap = {(run < 30 * ndiv), cap[7:1]};
      slot_cnt = slot_cnt + 1;
    end
    prev_oe = dq_oe;
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic bus_pop(output logic [15:0] d);
    @(negedge clk);
    addr = A_DATA; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic run_ctrl(input logic [15:0] v, input logic [15:0] mask,
                          output int low, output int busy);
    bus_write(A_CTRL, v);
    addr = A_CTRL;
    low = 0; busy = 0;
    while ((rdata & mask) != 0 && busy < 10000) begin
      busy++;
      if (dq_oe) low++;
      @(negedge clk);
    end
  endtask

  task automatic wait_stat(input logic [15:0] mask);
    int n = 0;
    addr = A_STAT;
    while ((rdata & mask) == 0 && n < 20000) begin
      @(negedge clk);
      addr = A_STAT;
      n++;
    end
  endtask

  task automatic t_reset_state;
    logic [15:0] d;
    bus_read(A_CTRL, d); check("R13 ctrl", d, 0);
    bus_read(A_STAT, d); check("R13 status", d, 16'h000C);
    bus_read(A_DIV, d);  check("R5 divider reset", d, 0);
    check("R13 line", dq_oe, 0);
    check("R13 irq", irq, 0);
  endtask

  task automatic t_reset_cycle(input logic present);
    int low, busy; logic [15:0] d;
    dev_low = present;
    run_ctrl(16'h0080, 16'h0080, low, busy);
    check("R1 reset low", low, 480 * ndiv);
    check("R1 reset length", busy, 960 * ndiv);
    dev_low = 1'b0;
    bus_read(A_CTRL, d);
    check("R2 presence", d[6], present);
    check("R1 bit7 cleared", d[7], 0);
  endtask

  task automatic t_write0;
    int low, busy; logic [15:0] d;
    run_ctrl(16'h0020, 16'h0020, low, busy);
    check("R3 write0 low", low, 60 * ndiv);
    check("R3 write0 length", busy, 70 * ndiv);
    bus_read(A_CTRL, d);
    check("R3 bit5 cleared", d[5], 0);
  endtask

  task automatic t_write1(input logic pull);
    int low, busy; logic [15:0] d;
    dev_low = pull;
    run_ctrl(16'h0010, 16'h0010, low, busy);
    dev_low = 1'b0;
    check("R4 write1 low", low, 6 * ndiv);
    check("R4 write1 length", busy, 70 * ndiv);
    bus_read(A_CTRL, d);
    check("R4 sampled bit", d[3], !pull);
  endtask

  task automatic t_divider;
    logic [15:0] d;
    bus_write(A_DIV, 16'd3); ndiv = 4;
    bus_read(A_DIV, d); check("R5 divider readback", d, 3);
    t_write0;
    bus_write(A_DIV, 16'd1); ndiv = 2;
  endtask

  task automatic t_busy_ignore;
    int low, busy; logic [15:0] d;
    bus_write(A_CTRL, 16'h0080);
    low = dq_oe ? 1 : 0; busy = 1;
    bus_write(A_CTRL, 16'h0020);
    low += 1; busy += 1;
    addr = A_CTRL;
    #1 d = rdata;
    check("R6 write0 ignored", d[5], 0);
    check("R6 reset still running", d[7], 1);
    while (rdata[7] && busy < 10000) begin
      busy++;
      if (dq_oe) low++;
      @(negedge clk);
    end
    check("R6 reset low unchanged", low, 480 * ndiv);
    check("R6 reset length unchanged", busy, 960 * ndiv);
  endtask

  task automatic t_byte_write;
    logic [15:0] d;
    slot_cnt = 0; dev_en = 1'b0; dev_low = 1'b0;
    bus_write(A_DATA, 16'h00A5);
    repeat (3) @(negedge clk);
    bus_read(A_STAT, d);
    check("R9 shifter busy", d[3], 0);
    check("R9 buffer drained", d[2], 1);
    wait_stat(16'h0010);
    bus_read(A_STAT, d);
    check("R8 status after byte", d, 16'h001C);
    check("R7 slot count", slot_cnt, 8);
    check("R7 slot kinds", cap, 8'hA5);
    bus_pop(d);
    check("R8 echo byte", d, 16'h00A5);
    bus_read(A_STAT, d);
    check("R8 rx full cleared", d[4], 0);
  endtask

  task automatic t_byte_read;
    logic [15:0] d;
    dev_pat = 16'h003C; dev_idx = 0; dev_en = 1'b1;
    bus_write(A_IEN, 16'h0010);
    bus_write(A_DATA, 16'h00FF);
    wait_stat(16'h0010);
    dev_en = 1'b0; dev_low = 1'b0;
    check("R11 irq on rx full", irq, 1);
    bus_read(A_STAT, d);
    check("R9 shifter empty", d[3], 1);
    bus_pop(d);
    check("R8 read byte", d, 16'h003C);
    check("R11 irq cleared", irq, 0);
    bus_write(A_IEN, 16'h0000);
  endtask

  task automatic t_two_bytes;
    logic [15:0] d;
    dev_pat = 16'h965A; dev_idx = 0; dev_en = 1'b1;
    bus_write(A_DATA, 16'h00FF);
    bus_write(A_DATA, 16'h00FF);
    bus_read(A_STAT, d);
    check("R9 second byte waits", d[2], 0);
    wait_stat(16'h0020);
    dev_en = 1'b0; dev_low = 1'b0;
    bus_read(A_STAT, d);
    check("R10 both full", d, 16'h003C);
    bus_pop(d);
    check("R10 older byte", d, 16'h005A);
    bus_read(A_STAT, d);
    check("R10 moved status", d, 16'h001C);
    bus_pop(d);
    check("R10 newer byte", d, 16'h0096);
    bus_read(A_STAT, d);
    check("R10 drained status", d, 16'h000C);
  endtask

  task automatic t_irq;
    bus_write(A_IEN, 16'h0004); #1;
    check("R11 irq tbe", irq, 1);
    bus_write(A_IEN, 16'h0020); #1;
    check("R11 irq masked", irq, 0);
    bus_write(A_IEN, 16'h0008); #1;
    check("R11 irq tsre", irq, 1);
    bus_write(A_IEN, 16'h0000); #1;
    check("R11 irq none", irq, 0);
  endtask

  task automatic t_soft_reset;
    logic [15:0] d;
    bus_write(A_CTRL, 16'h0080);
    repeat (20) @(negedge clk);
    check("R12 line low before abort", dq_oe, 1);
    bus_write(A_SRST, 16'h0001);
    check("R12 line released", dq_oe, 0);
    bus_read(A_CTRL, d);
    check("R12 ctrl idle", d & 16'h00B0, 0);
    bus_write(A_DATA, 16'h00FF);
    repeat (30) @(negedge clk);
    bus_write(A_SRST, 16'h0001);
    bus_read(A_STAT, d);
    check("R12 status restored", d, 16'h000C);
    check("R12 line after byte abort", dq_oe, 0);
    t_write0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state;
    bus_write(A_DIV, 16'd1); ndiv = 2;
    t_reset_cycle(1'b1);
    t_reset_cycle(1'b0);
    t_write0;
    t_write1(1'b0);
    t_write1(1'b1);
    t_divider;
    t_busy_ignore;
    t_byte_write;
    t_byte_read;
    t_two_bytes;
    t_irq;
    t_soft_reset;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule